// File: doc/BRIEF.md
# Ping-Pong Resampling Pitch Shifter

This block changes the pitch of a continuous stream of signed 8-bit audio samples. It takes one new sample on every active clock cycle. It never drops an input and never stalls its producer. It keeps two sample buffers of equal depth. One buffer fills with fresh input while the other is replayed at a fractional stride `alpha`. `alpha` is an unsigned fixed-point ratio, target pitch over source pitch. A stride above one speeds the replay up and raises the pitch. A stride below one slows it down.

The block treats each stored block as one period of a periodic signal. When the stride is large, the replay wraps around the same buffer, so the block is stretched in time and then resampled. Each output sample is a linear blend of two neighbouring stored samples, weighted by the fractional part of the read position.

A replay pass lasts exactly one buffer depth of cycles. On that cycle the freshly filled buffer has just received its last sample, and the two buffers exchange roles. Computing `alpha` from frequencies is done by the block's user. `alpha` is held steady for the duration of a pass.

Top module: `pshift_top`

## Requirements
- R1: While reset is low and after it, until the first output, `out_valid` is 0 and `out_sample` is 0.
- R2: During the first N active cycles after reset (N = 2^ADDR_W), only the fill buffer is written and no output is produced. The first `out_valid` appears after exactly the (N+2)-th rising edge that follows reset release.
- R3: `alpha` is unsigned with 12 fractional bits. The read position starts at 0 in each pass and grows by `alpha` every active cycle. Its integer part, taken modulo N, selects sample k, and sample (k+1) modulo N is fetched in the same cycle.
- R4: Each output equals floor((w·s[k+1] + (4096−w)·s[k]) / 4096), where w is the low 12 bits of the read position, and the output is signed 8-bit.
- R5: A pass ends on the active cycle in which the read position is at least alpha·(N−1). On that cycle the two buffers swap roles and the read position returns to 0. Every pass therefore yields exactly N outputs, drawn from the N inputs of the preceding pass.
- R6: The write address starts at 0 in each pass and increases by one on every active cycle that is not a swap cycle, so the j-th input of a pass is stored at location j. With alpha = 1.0, the output stream equals the input stream delayed by one pass.
- R7: `alpha` = 0 marks a cycle as inactive. On such a cycle the input sample is discarded, the read position, write address and buffer roles are frozen, and no output is produced. Once `alpha` is nonzero again, the stream resumes as if the inactive cycles had not occurred.
- R8: An output appears two rising edges after the active cycle that fetched its samples, and outputs keep the order of their reads.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| in_sample | input | SAMPLE_W | Signed input sample, taken on every active cycle |
| alpha | input | ALPHA_W | Unsigned pitch ratio, 12 fractional bits; 0 pauses the block |
| out_sample | output | SAMPLE_W | Signed interpolated output sample |
| out_valid | output | 1 | High for one cycle per output sample |

## Verification
The bench sweeps a few hundred stride values on a 16-entry configuration. The sweep includes the smallest stride, the largest stride, unity, exact integers and values just either side of 1.0. It compares every output against an arithmetic model.

A wrong wrap of the integer address would show up at large strides, as corrupted samples in the wrapped part of a pass. A misplaced swap threshold would give passes one output too long or too short, and the miscount would show in the totals. Unity stride exposes an off-by-one write address or a sample written on the swap cycle to the wrong buffer. Negative samples and the −128 and 127 extremes catch interpolation that truncates toward zero instead of flooring.

Pauses with a zero stride are placed mid-pass. A design that kept writing or advancing during a pause would shift every later output.

// File: rtl/pshift_pkg.sv
// Package: shared types for the pitch shifter.
// Assumes nothing beyond a two-buffer arrangement.
package pshift_pkg;

    // Which of the two sample buffers is currently being filled.
    typedef enum logic {
        BUF_A = 1'b0,
        BUF_B = 1'b1
    } buf_sel_e;

    // Role exchange of the two buffers.
    function automatic buf_sel_e other_buf(input buf_sel_e b);
        return (b == BUF_A) ? BUF_B : BUF_A;
    endfunction

endpackage

// File: rtl/pshift_bank.sv
// Module: one sample buffer.
// Synchronous write port, plus two registered read ports for the adjacent
// samples k and k+1. Contents are not reset; the control logic never
// replays a buffer before it has been completely filled.
module pshift_bank #(
    parameter int SAMPLE_W = 8,
    parameter int ADDR_W   = 12
) (
    input  logic                       clk,
    input  logic                       we,
    input  logic [ADDR_W-1:0]          waddr,
    input  logic signed [SAMPLE_W-1:0] wdata,
    input  logic [ADDR_W-1:0]          raddr0,
    input  logic [ADDR_W-1:0]          raddr1,
    output logic signed [SAMPLE_W-1:0] rdata0,
    output logic signed [SAMPLE_W-1:0] rdata1
);
    localparam int DEPTH = 1 << ADDR_W;

    logic signed [SAMPLE_W-1:0] mem [DEPTH];

    // Store the incoming sample at the write address.
    always_ff @(posedge clk) begin
        if (we) begin
            mem[waddr] <= wdata;
        end
    end

    // Fetch both neighbours for the interpolator in the same cycle.
    always_ff @(posedge clk) begin
        rdata0 <= mem[raddr0];
        rdata1 <= mem[raddr1];
    end
endmodule

// File: rtl/pshift_ctrl.sv
// Module: control for the pitch shifter.
// Holds the fractional read position, the write address and the buffer
// roles, and decides when a pass ends. Assumes alpha is steady within a
// pass; alpha == 0 freezes all state.
module pshift_ctrl #(
    parameter int ADDR_W  = 12,
    parameter int FRAC_W  = 12,
    parameter int ALPHA_W = 16
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [ALPHA_W-1:0]     alpha,
    output logic                   run,
    output logic                   swap,
    output pshift_pkg::buf_sel_e   wr_sel,
    output logic [ADDR_W-1:0]      wr_addr,
    output logic [ALPHA_W+ADDR_W-1:0] rd_idx,
    output logic [ADDR_W-1:0]      rd_addr0,
    output logic [ADDR_W-1:0]      rd_addr1,
    output logic                   primed,
    output logic                   stg_valid,
    output logic [FRAC_W-1:0]      stg_weight,
    output pshift_pkg::buf_sel_e   stg_sel
);
    import pshift_pkg::*;

    localparam int IDX_W = ALPHA_W + ADDR_W;

    logic [IDX_W-1:0] last_idx;

    // alpha*(N-1) computed as alpha*N - alpha, which needs no multiplier.
    assign last_idx = {alpha, {ADDR_W{1'b0}}} - IDX_W'(alpha);
    assign run      = (alpha != '0);
    assign swap     = run && (rd_idx >= last_idx);
    assign rd_addr0 = rd_idx[FRAC_W +: ADDR_W];
    assign rd_addr1 = rd_addr0 + ADDR_W'(1);

    // Advance the read position and write address, or restart both on a swap.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_idx  <= '0;
            wr_addr <= '0;
            wr_sel  <= BUF_A;
            primed  <= 1'b0;
        end else if (run) begin
            if (swap) begin
                rd_idx  <= '0;
                wr_addr <= '0;
                wr_sel  <= other_buf(wr_sel);
                primed  <= 1'b1;
            end else begin
                rd_idx  <= rd_idx + IDX_W'(alpha);
                wr_addr <= wr_addr + ADDR_W'(1);
            end
        end
    end

    // Carry the weight, validity and source buffer alongside the memory read.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stg_valid  <= 1'b0;
            stg_weight <= '0;
            stg_sel    <= BUF_B;
        end else begin
            stg_valid  <= run && primed;
            stg_weight <= rd_idx[FRAC_W-1:0];
            stg_sel    <= other_buf(wr_sel);
        end
    end
endmodule

// File: rtl/pshift_interp.sv
// Module: linear interpolator.
// Blends two adjacent signed samples using an unsigned weight with
// FRAC_W fractional bits. Floors the result and registers it.
// The blend is convex, so the result always fits SAMPLE_W bits.
module pshift_interp #(
    parameter int SAMPLE_W = 8,
    parameter int FRAC_W   = 12
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       in_valid,
    input  logic signed [SAMPLE_W-1:0] s_lo,
    input  logic signed [SAMPLE_W-1:0] s_hi,
    input  logic [FRAC_W-1:0]          weight,
    output logic signed [SAMPLE_W-1:0] out_sample,
    output logic                       out_valid
);
    localparam int WT_W  = FRAC_W + 2;
    localparam int ACC_W = SAMPLE_W + FRAC_W + 2;
    localparam logic signed [WT_W-1:0] UNITY = WT_W'(1 << FRAC_W);

    logic signed [WT_W-1:0]  w_hi;
    logic signed [WT_W-1:0]  w_lo;
    logic signed [ACC_W-1:0] acc;

    // Weighted sum of the two neighbours.
    always_comb begin
        w_hi = $signed({2'b00, weight});
        w_lo = UNITY - w_hi;
        acc  = ACC_W'(s_hi) * ACC_W'(w_hi) + ACC_W'(s_lo) * ACC_W'(w_lo);
    end

    // Register the floored result and its strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_sample <= '0;
            out_valid  <= 1'b0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                out_sample <= SAMPLE_W'(acc >>> FRAC_W);
            end
        end
    end
endmodule

// File: rtl/pshift_top.sv
// Module: ping-pong resampling pitch shifter.
// Fills one buffer with the input stream while it replays the other at a
// fractional stride alpha (FRAC_W fractional bits), wrapping within the
// buffer. The buffers swap once per pass of N cycles.
// Assumes alpha is steady within a pass.
module pshift_top #(
    parameter int SAMPLE_W = 8,
    parameter int ADDR_W   = 12,
    parameter int FRAC_W   = 12,
    parameter int ALPHA_W  = 16
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic signed [SAMPLE_W-1:0] in_sample,
    input  logic [ALPHA_W-1:0]         alpha,
    output logic signed [SAMPLE_W-1:0] out_sample,
    output logic                       out_valid
);
    import pshift_pkg::*;

    localparam int IDX_W = ALPHA_W + ADDR_W;

    logic                       run;
    logic                       swap;
    buf_sel_e                   wr_sel;
    logic [ADDR_W-1:0]          wr_addr;
    logic [IDX_W-1:0]           rd_idx;
    logic [ADDR_W-1:0]          rd_addr0;
    logic [ADDR_W-1:0]          rd_addr1;
    logic                       primed;
    logic                       stg_valid;
    logic [FRAC_W-1:0]          stg_weight;
    buf_sel_e                   stg_sel;
    logic signed [SAMPLE_W-1:0] bank_r0 [2];
    logic signed [SAMPLE_W-1:0] bank_r1 [2];
    logic signed [SAMPLE_W-1:0] s_lo;
    logic signed [SAMPLE_W-1:0] s_hi;

    pshift_ctrl #(
        .ADDR_W (ADDR_W),
        .FRAC_W (FRAC_W),
        .ALPHA_W(ALPHA_W)
    ) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .alpha     (alpha),
        .run       (run),
        .swap      (swap),
        .wr_sel    (wr_sel),
        .wr_addr   (wr_addr),
        .rd_idx    (rd_idx),
        .rd_addr0  (rd_addr0),
        .rd_addr1  (rd_addr1),
        .primed    (primed),
        .stg_valid (stg_valid),
        .stg_weight(stg_weight),
        .stg_sel   (stg_sel)
    );

    for (genvar b = 0; b < 2; b++) begin : g_bank
        pshift_bank #(
            .SAMPLE_W(SAMPLE_W),
            .ADDR_W  (ADDR_W)
        ) u_bank (
            .clk   (clk),
            .we    (run && (wr_sel == ((b == 0) ? BUF_A : BUF_B))),
            .waddr (wr_addr),
            .wdata (in_sample),
            .raddr0(rd_addr0),
            .raddr1(rd_addr1),
            .rdata0(bank_r0[b]),
            .rdata1(bank_r1[b])
        );
    end

    // Pick the neighbours from the buffer that was being replayed at read time.
    always_comb begin
        s_lo = (stg_sel == BUF_B) ? bank_r0[1] : bank_r0[0];
        s_hi = (stg_sel == BUF_B) ? bank_r1[1] : bank_r1[0];
    end

    pshift_interp #(
        .SAMPLE_W(SAMPLE_W),
        .FRAC_W  (FRAC_W)
    ) u_interp (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (stg_valid),
        .s_lo      (s_lo),
        .s_hi      (s_hi),
        .weight    (stg_weight),
        .out_sample(out_sample),
        .out_valid (out_valid)
    );
endmodule

// File: rtl/pshift_top_chk.sv
// Module: assertion checker for pshift_top, attached with bind.
// Observes the top-level ports and the nets joining the control block to
// the buffers and the interpolator.
module pshift_top_chk #(
    parameter int ADDR_W  = 12,
    parameter int ALPHA_W = 16
) (
    input logic                      clk,
    input logic                      rst_n,
    input logic [ALPHA_W-1:0]        alpha,
    input logic                      out_valid,
    input logic                      run,
    input logic                      swap,
    input logic                      primed,
    input pshift_pkg::buf_sel_e      wr_sel,
    input logic [ADDR_W-1:0]         wr_addr,
    input logic [ALPHA_W+ADDR_W-1:0] rd_idx
);
    localparam int IDX_W = ALPHA_W + ADDR_W;

    AST_RESET_QUIET: assert property (@(posedge clk) !rst_n |=> !out_valid); // R1
    AST_FILL_SILENT: assert property (@(posedge clk) disable iff (!rst_n) !primed |=> ##1 !out_valid); // R2
    AST_IDX_STEP: assert property (@(posedge clk) disable iff (!rst_n) (run && !swap) |=> rd_idx == $past(rd_idx) + IDX_W'($past(alpha))); // R3
    AST_SWAP_RESTART: assert property (@(posedge clk) disable iff (!rst_n) swap |=> (rd_idx == '0 && wr_addr == '0)); // R5
    AST_SWAP_FLIP: assert property (@(posedge clk) disable iff (!rst_n) swap |=> wr_sel != $past(wr_sel)); // R5
    AST_WR_STEP: assert property (@(posedge clk) disable iff (!rst_n) (run && !swap) |=> wr_addr == ADDR_W'($past(wr_addr) + ADDR_W'(1))); // R6
    AST_PAUSE_HOLD: assert property (@(posedge clk) disable iff (!rst_n) !run |=> ($stable(rd_idx) && $stable(wr_addr) && $stable(wr_sel))); // R7
    AST_PAUSE_SILENT: assert property (@(posedge clk) disable iff (!rst_n) (alpha == '0) |=> ##1 !out_valid); // R7
endmodule

bind pshift_top pshift_top_chk #(
    .ADDR_W (ADDR_W),
    .ALPHA_W(ALPHA_W)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .alpha    (alpha),
    .out_valid(out_valid),
    .run      (run),
    .swap     (swap),
    .primed   (primed),
    .wr_sel   (wr_sel),
    .wr_addr  (wr_addr),
    .rd_idx   (rd_idx)
);

// File: tb/pshift_top_test.sv
`timescale 1ns/1ps
module pshift_top_test;
    localparam int AW = 4;
    localparam int N  = 1 << AW;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic signed [7:0] in_sample = '0;
    logic [15:0]       alpha = 16'h1000;
    logic signed [7:0] out_sample;
    logic              out_valid;

    int checks = 0;
    int errors = 0;
    int edge_n, cnt, first_v, seed, wr_j;
    logic [15:0] run_alpha;

    always #5 clk = ~clk;

    pshift_top #(.ADDR_W(AW)) uut (
        .clk(clk), .rst_n(rst_n), .in_sample(in_sample), .alpha(alpha),
        .out_sample(out_sample), .out_valid(out_valid)
    );

    // Test signal: mixes sequence and seed, with forced extremes.
    function automatic int sig(input int sd, input int j);
        int v;
        v = (j * 29 + sd * 53 + (j / 8) * 7) % 256;
        if (j % 11 == 3) v = 128;
        if (j % 13 == 5) v = 127;
        return (v >= 128) ? v - 256 : v;
    endfunction

    // Expected c-th output of a run: pass c/N replays inputs of the prior pass.
    function automatic int model(input int sd, input logic [15:0] a, input int c);
        longint idx;
        int p, m, k, k1, w, s0, s1, acc;
        p   = c / N;
        m   = c % N;
        idx = longint'(m) * longint'(a);
        k   = int'((idx >>> 12) % N);
        k1  = (k + 1) % N;
        w   = int'(idx & 4095);
        s0  = sig(sd, p * N + k);
        s1  = sig(sd, p * N + k1);
        acc = w * s1 + (4096 - w) * s0;
        return acc >>> 12;
    endfunction

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d (alpha %h)", tag, act, exp, run_alpha);
        end
    endtask

    // Compare any output present after the last edge.
    task automatic observe();
        string tag;
        if (out_valid) begin
            if (first_v < 0) first_v = edge_n;
            if (run_alpha == 16'h1000) tag = "R6";
            else if (run_alpha[11:0] == 12'h000) tag = "R3";
            else tag = "R4";
            check(tag, int'(out_sample), model(seed, run_alpha, cnt));
            cnt++;
        end
    endtask

    // One cycle: drive at the falling edge, sample after the next rising edge.
    task automatic tick(input logic [15:0] a_v, input logic signed [7:0] s_v);
        alpha     = a_v;
        in_sample = s_v;
        @(posedge clk);
        edge_n++;
        if (a_v != 16'h0) wr_j++;
        @(negedge clk);
        observe();
    endtask

    task automatic one_run(input logic [15:0] a, input int sd, input bit pause);
        run_alpha = a;
        seed      = sd;
        rst_n     = 1'b0;
        alpha     = a;
        repeat (2) @(posedge clk);
        @(negedge clk);
        check("R1", int'(out_valid), 0);
        check("R1", int'(out_sample), 0);
        rst_n   = 1'b1;
        edge_n  = 0;
        cnt     = 0;
        first_v = -1;
        wr_j    = 0;
        while (wr_j < 4 * N + 2) begin
            if (pause && wr_j == 2 * N + 5) begin
                for (int s = 0; s < 6; s++) begin
                    tick(16'h0, 8'sh55 ^ 8'(s));
                    if (s >= 1) check("R7", int'(out_valid), 0);
                end
            end
            tick(a, 8'(sig(sd, wr_j)));
        end
        for (int d = 0; d < 3; d++) tick(16'h0, 8'sh00);
        check("R5", cnt, 3 * N + 2);
        if (!pause) check("R2", first_v, N + 2);
        else check("R8", first_v, N + 2);
    endtask

    initial begin
        logic [15:0] specials [10];
        specials = '{16'h1000, 16'h2000, 16'h1428, 16'h0800, 16'h0001,
                     16'hFFFF, 16'h0FFF, 16'h1001, 16'h3000, 16'h8000};
        @(negedge clk);
        for (int i = 0; i < 10; i++) one_run(specials[i], i, (i % 3) == 1);
        for (int k = 0; k < 200; k++) begin
            logic [15:0] a;
            a = 16'((k * 331 + 7) & 16'hFFFF);
            if (a == 16'h0) a = 16'h0002;
            one_run(a, k + 17, (k % 7) == 3);
        end
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL R5 watchdog expired actual 0 expected 1");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule